// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow side register

This unit carries out the arithmetic, shift and bitwise operations of a small 16-bit processor. The sequencer presents the current value of the destination operand (`a_in`), the source operand (`b_in`) and a 6-bit operation code, together with a one-cycle `start` strobe. The unit then returns the new destination value on `result` and a `done` pulse. Operations with a side result also return a new value for the processor's 16-bit overflow register on `o_out`, qualified by `o_we`. When `o_we` is low, the sequencer must leave its overflow register as it is.

The unit's latency matches the instruction cycle costs of the processor. Plain operations complete one cycle after they are accepted. Multiply takes two cycles. Divide, modulo and negate take three. While a two- or three-cycle operation is in flight, `busy` is high and any `start` is dropped. The sequencer may present a new operation in the cycle in which `done` is high. Division and modulo by zero do not trap: they return zero.

Top module: `ovf_alu`

## Requirements
- R1: ADD (0x02) returns a+b mod 2^16 and writes O = 0x0001 on a carry out of bit 15, 0x0000 otherwise. SUB (0x03) returns a−b mod 2^16 and writes O = 0xFFFF when b > a (borrow), 0x0000 otherwise.
- R2: MUL (0x04) returns the low 16 bits of the unsigned 32-bit product a*b and writes O = the high 16 bits.
- R3: DIV (0x05) returns a/b and writes O = ((a·2^16)/b) mod 2^16. With b = 0 it returns 0 and writes O = 0. MOD (0x06) returns a mod b (0 when b = 0) and does not write O.
- R4: SHL (0x07) forms the 32-bit value a<<b and returns its low half, writing O = its high half. SHR (0x08) forms (a·2^16)>>b and returns its high half (a>>b), writing O = its low half. A shift amount b ≥ 32 returns 0 and writes O = 0.
- R5: SET (0x01) returns b. AND (0x09), BOR (0x0A) and XOR (0x0B) return a&b, a|b and a^b. NOT (0x10) returns ~b. NEG (0x11) returns (−b) mod 2^16. None of these writes O (o_we stays 0).
- R6: Let k be the edge at which `start` is accepted. `done` is high for exactly one cycle, in the cycle after edge k+L−1, where L = 2 for MUL, L = 3 for DIV, MOD and NEG, and L = 1 for all other codes. `result`, `o_out` and `o_we` are valid in that cycle, and `o_we` is never high outside a `done` cycle.
- R7: `busy` is high from the edge that accepts a MUL, DIV, MOD or NEG until the cycle in which its `done` is high; that cycle is excluded. A `start` seen while `busy` is high is ignored: it neither changes the operation in flight nor creates a further `done`.
- R8: Any opcode not listed in R1–R5 (for example 0x12 or 0x3F) completes with L = 1, returns a unchanged and does not write O.
- R9: While `rst_n` is low, and directly after reset, `done`, `o_we` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch an operation with the current opcode and operands |
| opcode | input | 6 | Operation code (see R1–R8) |
| a_in | input | 16 | Destination operand, current value |
| b_in | input | 16 | Source operand |
| result | output | 16 | New destination value, valid with done |
| o_out | output | 16 | New overflow register value, valid with o_we |
| o_we | output | 1 | Overflow register write enable |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A multi-cycle operation is in flight; start is ignored |

## Verification
The hardest cases to reach are a `start` that arrives while a three-cycle divide is still in flight, and a new launch in the exact cycle that a multiply's `done` appears. The stimulus reaches them by issuing back-to-back starts with different opcodes right after a long operation. The bench expects the intruding operations to vanish and the launch on the done cycle to be taken. A random phase then mixes opcodes, strobe density and small shift amounts, so that these overlaps recur many times beside the directed corner operands (carry, borrow, zero divisor, shift by 32 and more).

// File: rtl/ovf_alu_pkg.sv
// Package: opcode values and latency constants shared by the ALU modules.
// Assumes a 6-bit operation code field.
package ovf_alu_pkg;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 2;

    localparam logic [5:0] OP_SET = 6'h01;
    localparam logic [5:0] OP_ADD = 6'h02;
    localparam logic [5:0] OP_SUB = 6'h03;
    localparam logic [5:0] OP_MUL = 6'h04;
    localparam logic [5:0] OP_DIV = 6'h05;
    localparam logic [5:0] OP_MOD = 6'h06;
    localparam logic [5:0] OP_SHL = 6'h07;
    localparam logic [5:0] OP_SHR = 6'h08;
    localparam logic [5:0] OP_AND = 6'h09;
    localparam logic [5:0] OP_BOR = 6'h0A;
    localparam logic [5:0] OP_XOR = 6'h0B;
    localparam logic [5:0] OP_NOT = 6'h10;
    localparam logic [5:0] OP_NEG = 6'h11;

    localparam logic [CNT_W-1:0] LAT_SHORT = 2'd1;
    localparam logic [CNT_W-1:0] LAT_MUL   = 2'd2;
    localparam logic [CNT_W-1:0] LAT_LONG  = 2'd3;

    // Cycles from acceptance to done for a given opcode.
    function automatic logic [CNT_W-1:0] op_latency(input logic [5:0] op);
        case (op)
            OP_MUL:                 return LAT_MUL;
            OP_DIV, OP_MOD, OP_NEG: return LAT_LONG;
            default:                return LAT_SHORT;
        endcase
    endfunction
endpackage

// File: rtl/ovf_alu_short.sv
// Module: single-cycle datapath (copy, add, subtract, shifts, bitwise, pass-through).
// Assumes W > log2(2*W) so the shift-amount range test has upper bits to look at.
module ovf_alu_short
    import ovf_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [5:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] ovf,
    output logic         owe
);
    localparam int SHW = $clog2(2 * W);

    logic [W:0]     sum, dif;
    logic [2*W-1:0] wl, wr;
    logic           too_far;

    // Shared adders and the 2W-bit shift intermediates.
    always_comb begin
        sum     = {1'b0, a} + {1'b0, b};
        dif     = {1'b0, a} - {1'b0, b};
        too_far = |b[W-1:SHW];
        wl      = {{W{1'b0}}, a} << b[SHW-1:0];
        wr      = {a, {W{1'b0}}} >> b[SHW-1:0];
        if (too_far) begin
            wl = '0;
            wr = '0;
        end
    end

    // Select the operation result and its overflow side value.
    always_comb begin
        res = a;
        ovf = '0;
        owe = 1'b0;
        case (op)
            OP_SET: res = b;
            OP_ADD: begin res = sum[W-1:0]; ovf = W'(sum[W]); owe = 1'b1; end
            OP_SUB: begin res = dif[W-1:0]; ovf = {W{dif[W]}}; owe = 1'b1; end
            OP_SHL: begin res = wl[W-1:0]; ovf = wl[2*W-1:W]; owe = 1'b1; end
            OP_SHR: begin res = wr[2*W-1:W]; ovf = wr[W-1:0]; owe = 1'b1; end
            OP_AND: res = a & b;
            OP_BOR: res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/ovf_alu_long.sv
// Module: datapath for the multi-cycle codes (multiply, divide, modulo, negate).
// Assumes unsigned operands; a zero divisor yields zero results.
module ovf_alu_long
    import ovf_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [5:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         sel,
    output logic [W-1:0] res,
    output logic [W-1:0] ovf,
    output logic         owe
);
    logic [2*W-1:0] prod, qlo, qhi;
    logic [W-1:0]   rem;
    logic           bz;

    // Product, the two quotients and the remainder, guarded against b == 0.
    always_comb begin
        bz   = (b == '0);
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        qlo  = '0;
        qhi  = '0;
        rem  = '0;
        if (!bz) begin
            qlo = {{W{1'b0}}, a} / {{W{1'b0}}, b};
            qhi = {a, {W{1'b0}}} / {{W{1'b0}}, b};
            rem = a % b;
        end
    end

    // Select the result of the multi-cycle code in use.
    always_comb begin
        sel = 1'b1;
        res = '0;
        ovf = '0;
        owe = 1'b0;
        case (op)
            OP_MUL: begin res = prod[W-1:0]; ovf = prod[2*W-1:W]; owe = 1'b1; end
            OP_DIV: begin res = qlo[W-1:0]; ovf = qhi[W-1:0]; owe = 1'b1; end
            OP_MOD: res = rem;
            OP_NEG: res = (~b) + W'(1);
            default: sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/ovf_alu_timer.sv
// Module: latency counter. It accepts a launch when idle or on the done cycle,
// holds busy while a longer latency runs, and pulses done once.
module ovf_alu_timer
    import ovf_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] lat,
    output logic             accept,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Decode the counter state.
    always_comb begin
        busy   = (cnt_q > CNT_W'(1));
        done   = (cnt_q == CNT_W'(1));
        accept = start && !busy;
    end

    // Load the latency on acceptance, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (accept)     cnt_q <= lat;
        else if (cnt_q != 0) cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/ovf_alu.sv
// Module: top of the ALU. It computes on acceptance, holds the result, and
// releases it with done after the opcode's latency.
// Assumes the caller keeps the overflow register and writes it on o_we.
module ovf_alu
    import ovf_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [5:0]   opcode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] result,
    output logic [W-1:0] o_out,
    output logic         o_we,
    output logic         done,
    output logic         busy
);
    logic [W-1:0] s_res, s_ovf, l_res, l_ovf, n_res, n_ovf;
    logic         s_owe, l_owe, l_sel, n_owe, accept;
    logic [W-1:0] res_q, ovf_q;
    logic         owe_q;

    ovf_alu_short #(.W(W)) u_short (
        .op(opcode), .a(a_in), .b(b_in), .res(s_res), .ovf(s_ovf), .owe(s_owe)
    );

    ovf_alu_long #(.W(W)) u_long (
        .op(opcode), .a(a_in), .b(b_in), .sel(l_sel), .res(l_res), .ovf(l_ovf), .owe(l_owe)
    );

    ovf_alu_timer u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .lat(op_latency(opcode)),
        .accept(accept), .busy(busy), .done(done)
    );

    // Pick the output of the datapath that owns the opcode.
    always_comb begin
        n_res = l_sel ? l_res : s_res;
        n_ovf = l_sel ? l_ovf : s_ovf;
        n_owe = l_sel ? l_owe : s_owe;
    end

    // Capture the outcome when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ovf_q <= '0;
            owe_q <= 1'b0;
        end else if (accept) begin
            res_q <= n_res;
            ovf_q <= n_ovf;
            owe_q <= n_owe;
        end
    end

    // Drive the outputs; the overflow write is allowed only with done.
    always_comb begin
        result = res_q;
        o_out  = ovf_q;
        o_we   = done && owe_q;
    end
endmodule

// File: rtl/ovf_alu_chk.sv
// Checker: timing and corner-case properties of ovf_alu, attached by bind.
module ovf_alu_chk
    import ovf_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [5:0]   opcode,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] result,
    input logic [W-1:0] o_out,
    input logic         o_we,
    input logic         done,
    input logic         busy
);
    logic acc, is_mul, is_long3, is_short, is_bitop, is_odd;
    always_comb begin
        acc      = start && !busy;
        is_mul   = (opcode == OP_MUL);
        is_long3 = (opcode == OP_DIV) || (opcode == OP_MOD) || (opcode == OP_NEG);
        is_short = !is_mul && !is_long3;
        is_bitop = (opcode == OP_AND) || (opcode == OP_BOR) || (opcode == OP_XOR)
                || (opcode == OP_NOT) || (opcode == OP_SET);
        is_odd   = (opcode == 6'h3F) || (opcode == 6'h12);
    end

    assert_short_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_short) |=> done);
    assert_mul_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_mul) |=> !done ##1 done);
    assert_long_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_long3) |=> !done ##1 !done ##1 done);
    assert_owe_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        o_we |-> done);
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(result) && $stable(o_out)));
    assert_div_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opcode == OP_DIV && b_in == '0) |=> ##2 (done && o_we && result == '0 && o_out == '0));
    assert_bitop_no_o_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_bitop) |=> (done && !o_we));
    assert_odd_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_odd) |=> (done && !o_we && result == $past(a_in)));
    assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && opcode == OP_ADD && ({1'b0, a_in} + {1'b0, b_in}) > {1'b0, {W{1'b1}}})
        |=> (o_we && o_out == W'(1)));
endmodule

bind ovf_alu ovf_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_ovf_alu.sv
// Bench: behavioural reference model compared with the ALU outputs every cycle.
module test_ovf_alu;
    localparam logic [5:0] SET = 6'h01, ADD = 6'h02, SUB = 6'h03, MUL = 6'h04,
        DIV = 6'h05, MOD = 6'h06, SHL = 6'h07, SHR = 6'h08, AND_ = 6'h09,
        BOR = 6'h0A, XOR_ = 6'h0B, NOT_ = 6'h10, NEG = 6'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] result, o_out;
    logic        o_we, done, busy;

    int checks = 0, errors = 0;
    int m_cnt = 0;
    logic [5:0]  m_op = '0;
    longint      m_res = 0, m_o = 0;
    bit          m_owe = 0;

    always #2 clk = ~clk;

    ovf_alu i_ovf_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .a_in(a_in),
        .b_in(b_in), .result(result), .o_out(o_out), .o_we(o_we), .done(done), .busy(busy)
    );

    function automatic string tag(input logic [5:0] op);
        case (op)
            ADD, SUB: return "R1";
            MUL: return "R2";
            DIV, MOD: return "R3";
            SHL, SHR: return "R4";
            SET, AND_, BOR, XOR_, NOT_, NEG: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference behaviour from the requirements, in plain integer arithmetic.
    task automatic ref_eval(input logic [5:0] op, input longint a, input longint b,
                            output longint r, output longint o, output bit w, output int lat);
        longint t;
        r = a; o = 0; w = 0; lat = 1;
        case (op)
            SET: r = b;
            ADD: begin t = a + b; r = t % 65536; o = (t > 65535) ? 1 : 0; w = 1; end
            SUB: begin r = (a - b + 65536) % 65536; o = (b > a) ? 65535 : 0; w = 1; end
            MUL: begin t = a * b; r = t % 65536; o = t / 65536; w = 1; lat = 2; end
            DIV: begin
                if (b == 0) begin r = 0; o = 0; end
                else begin r = a / b; o = ((a * 65536) / b) % 65536; end
                w = 1; lat = 3;
            end
            MOD: begin r = (b == 0) ? 0 : a % b; lat = 3; end
            SHL: begin
                if (b >= 32) begin r = 0; o = 0; end
                else begin t = a << b; r = t % 65536; o = (t / 65536) % 65536; end
                w = 1;
            end
            SHR: begin
                if (b >= 32) begin r = 0; o = 0; end
                else begin t = (a * 65536) >> b; r = (a >> b) % 65536; o = t % 65536; end
                w = 1;
            end
            AND_: r = a & b;
            BOR:  r = a | b;
            XOR_: r = a ^ b;
            NOT_: r = 65535 - b;
            NEG:  begin r = (65536 - b) % 65536; lat = 3; end
            default: r = a;
        endcase
    endtask

    // One clock: drive, advance the model at the edge, then compare.
    task automatic cyc(input bit st, input logic [5:0] op, input logic [15:0] a, input logic [15:0] b);
        longint r, o;
        bit w;
        int lat;
        start = st; opcode = op; a_in = a; b_in = b;
        @(posedge clk);
        if (st && !(m_cnt > 1)) begin
            ref_eval(op, longint'(a), longint'(b), r, o, w, lat);
            m_cnt = lat; m_op = op; m_res = r; m_o = o; m_owe = w;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        #1;
        chk(busy == (m_cnt > 1), "R7", "busy", longint'(busy), longint'(m_cnt > 1));
        chk(done == (m_cnt == 1), "R6", "done", longint'(done), longint'(m_cnt == 1));
        if (m_cnt == 1) begin
            chk(longint'(result) == m_res, tag(m_op), "result", longint'(result), m_res);
            chk(o_we == m_owe, tag(m_op), "o_we", longint'(o_we), longint'(m_owe));
            if (m_owe) chk(longint'(o_out) == m_o, tag(m_op), "o_out", longint'(o_out), m_o);
        end else begin
            chk(!o_we, "R6", "o_we outside done", longint'(o_we), 0);
        end
    endtask

    task automatic run(input logic [5:0] op, input logic [15:0] a, input logic [15:0] b);
        cyc(1'b1, op, a, b);
        for (int i = 0; i < 3; i++) cyc(1'b0, 6'h00, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] ops [13] = '{SET, ADD, SUB, MUL, DIV, MOD, SHL, SHR, AND_, BOR, XOR_, NOT_, NEG};
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(!done && !o_we && !busy, "R9", "outputs in reset",
            longint'({done, o_we, busy}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 6'h00, 16'h0, 16'h0);
        chk(!done && !o_we && !busy, "R9", "outputs after reset",
            longint'({done, o_we, busy}), 0);

        // R1 carry and borrow corners
        run(ADD, 16'hFFFF, 16'h0001);
        run(ADD, 16'h0001, 16'h0002);
        run(SUB, 16'h0000, 16'h0001);
        run(SUB, 16'h0005, 16'h0003);
        // R2 largest product
        run(MUL, 16'hFFFF, 16'hFFFF);
        // R3 quotients and zero divisor
        run(DIV, 16'h0007, 16'h0002);
        run(DIV, 16'h1234, 16'h0000);
        run(MOD, 16'h0011, 16'h0005);
        run(MOD, 16'h0007, 16'h0000);
        // R4 shifts, including 16..31 and 32 and beyond
        run(SHL, 16'h8001, 16'h0001);
        run(SHL, 16'h0001, 16'h0014);
        run(SHL, 16'hFFFF, 16'h0020);
        run(SHR, 16'h8001, 16'h0001);
        run(SHR, 16'hFFFF, 16'h0011);
        run(SHR, 16'hFFFF, 16'h0028);
        // R5 bitwise, copy, negate
        run(SET, 16'h1111, 16'hBEEF);
        run(AND_, 16'hF0F0, 16'h3C3C);
        run(BOR, 16'hF0F0, 16'h3C3C);
        run(XOR_, 16'hF0F0, 16'h3C3C);
        run(NOT_, 16'h0000, 16'h00FF);
        run(NEG, 16'h0000, 16'h0001);
        run(NEG, 16'h0000, 16'h0000);
        // R8 unlisted codes pass a through
        run(6'h3F, 16'hABCD, 16'h1234);
        run(6'h12, 16'h0042, 16'h0001);

        // R7: starts during a divide are dropped
        cyc(1'b1, DIV, 16'd100, 16'd7);
        cyc(1'b1, ADD, 16'hFFFF, 16'hFFFF);
        cyc(1'b1, SET, 16'h0, 16'h5555);
        cyc(1'b0, 6'h00, 16'h0, 16'h0);
        // R6/R7: launch on the done cycle of a multiply is accepted
        cyc(1'b1, MUL, 16'd300, 16'd500);
        cyc(1'b0, 6'h00, 16'h0, 16'h0);
        cyc(1'b1, ADD, 16'd10, 16'd20);
        cyc(1'b1, SHL, 16'h00F0, 16'd12);
        cyc(1'b0, 6'h00, 16'h0, 16'h0);

        // Mixed random traffic (R1-R8)
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra, rb;
            logic [5:0]  rop;
            ra  = 16'($urandom);
            rb  = 16'($urandom);
            rop = ops[$urandom % 13];
            if (($urandom % 4) == 0) rb = 16'($urandom % 40);
            if (($urandom % 8) == 0) rb = 16'h0;
            if (($urandom % 16) == 0) rop = 6'($urandom);
            cyc(($urandom % 5) < 3, rop, ra, rb);
        end
        for (int i = 0; i < 4; i++) cyc(1'b0, 6'h00, 16'h0, 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule